// File: doc/BRIEF.md
# Three-Phase Dead-Time Inserter

This block sits between a three-phase drive pattern source and the gate drivers of a bridge. Each phase has a complementary pair of drive signals, one for the high side and one for the low side. When either signal of a pair is asked to go from inactive to active, the block holds that signal inactive for a programmed number of count-source ticks. This gives the opposite switch time to turn off before the new one turns on. A request to go from active to inactive passes straight through.

The delay length is set by an 8-bit value with a legal range of 1 to 255. A select input chooses which of two tick enables clocks the delay count. Each pair has its own timer, so the three phases are delayed independently. A bypass input turns the delay off entirely, and the outputs then follow the request.

Top module: `deadtime_inserter`

## Requirements
- R1: While reset is high, and on the first edge after it, all six outputs are inactive (0) and no delay count is running.
- R2: Bit 2p of the request and output buses is the high-side signal of pair p, and bit 2p+1 is the low-side signal of pair p. A 1 means active. When bypass is low, a 0-to-1 change of a request bit keeps that output at 0 and starts the delay count of its pair.
- R3: Ticks are counted from the edge after the trigger edge. The held output takes its requested value at the edge where the n-th selected tick is sampled. With a tick in every cycle, the output rises on the (n+1)-th rising clock edge after the request is applied.
- R4: An active-to-inactive request reaches the output at the next rising edge, with no delay.
- R5: A new 0-to-1 request in a pair while its count is running restarts that count from zero.
- R6: While bypass is 1, every output equals its request one edge later. Any pending hold is dropped.
- R7: When src_sel is 0 the count uses tick_a, and when it is 1 the count uses tick_b. The unselected tick has no effect.
- R8: The delay length is captured at the trigger. A change to dly_len during a count does not change that count's length.
- R9: A delay value of 0 is treated as 1.
- R10: The three pairs count independently. A trigger in one pair does not change the release time of another pair.
- R11: With bypass low, and with no request that has both signals of a pair active, the two outputs of a pair are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_req | input | 6 | Requested drive pattern, high side at even bits |
| tick_a | input | 1 | Count-source enable 0 |
| tick_b | input | 1 | Count-source enable 1 |
| src_sel | input | 1 | Count-source select |
| dly_len | input | 8 | Delay length in ticks |
| bypass | input | 1 | 1 turns the delay off |
| drv_out | output | 6 | Gated drive signals |

## Verification
The bench builds the block with its default parameters: three pairs and an 8-bit delay length. With these defaults, the full legal delay of 255 ticks can be reached and measured end to end, as can the 0-as-1 corner. Random traffic uses short delays and a mix of tick densities. This makes restarts, bypass toggles and source switches overlap with running counts across all three pairs.

// File: rtl/dti_pkg.sv
package dti_pkg;

    // One complementary pair: pos is bit 0, neg is bit 1.
    typedef struct packed {
        logic neg;
        logic pos;
    } pair_drv_t;

    typedef enum logic {
        SRC_TICK_A = 1'b0,
        SRC_TICK_B = 1'b1
    } tick_src_e;

    function automatic logic pick_tick(tick_src_e sel, logic ta, logic tb);
        return (sel == SRC_TICK_B) ? tb : ta;
    endfunction

    function automatic pair_drv_t rising_bits(pair_drv_t now, pair_drv_t prev);
        pair_drv_t r;
        r.pos = now.pos & ~prev.pos;
        r.neg = now.neg & ~prev.neg;
        return r;
    endfunction

endpackage

// File: rtl/dti_tick_sel.sv
module dti_tick_sel
    import dti_pkg::*;
(
    input  logic src_sel,
    input  logic tick_a,
    input  logic tick_b,
    output logic tick
);
    tick_src_e sel_e;

    assign sel_e = tick_src_e'(src_sel);
    assign tick  = pick_tick(sel_e, tick_a, tick_b);

endmodule

// File: rtl/dti_pair_timer.sv
module dti_pair_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cancel,
    input  logic             tick,
    input  logic [DLY_W-1:0] len,
    output logic             busy,
    output logic             done
);
    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] len_q;
    logic [DLY_W-1:0] len_eff;
    logic             last;

    // A zero length behaves as one tick.
    assign len_eff = (len == '0) ? DLY_W'(1) : len;
    assign last    = (cnt == DLY_W'(len_q - DLY_W'(1)));
    assign done    = busy & tick & last & ~start & ~cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            len_q <= DLY_W'(1);
        end else if (cancel) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            len_q <= len_eff;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy && tick) begin
            cnt <= cnt + DLY_W'(1);
        end
    end

    // R8: a running count stays below its captured length
    a_r8_cnt_below_len: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < len_q));

    // R5: a trigger restarts the count from zero
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
        (start && !cancel) |=> (busy && cnt == '0));

    // R3: the count stops at its end
    a_r3_done_stops: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/dti_pair_gate.sv
module dti_pair_gate
    import dti_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pair_drv_t req,
    input  pair_drv_t rise,
    input  logic      done,
    input  logic      bypass,
    output pair_drv_t out
);
    pair_drv_t pend;
    pair_drv_t pend_nxt;
    pair_drv_t out_nxt;

    always_comb begin
        if (bypass) begin
            pend_nxt = '0;
        end else begin
            pend_nxt = (done ? pair_drv_t'(2'b00) : pend) | rise;
            pend_nxt = pend_nxt & req;
        end
        out_nxt = req & ~pend_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            out  <= '0;
        end else begin
            pend <= pend_nxt;
            out  <= out_nxt;
        end
    end

    // R4: inactive requests pass on the next edge
    a_r4_fall_pos: assert property (@(posedge clk) disable iff (rst)
        !req.pos |=> !out.pos);
    a_r4_fall_neg: assert property (@(posedge clk) disable iff (rst)
        !req.neg |=> !out.neg);

endmodule

// File: rtl/deadtime_inserter.sv
module deadtime_inserter
    import dti_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int DLY_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2*NUM_PAIRS-1:0] drv_req,
    input  logic                   tick_a,
    input  logic                   tick_b,
    input  logic                   src_sel,
    input  logic [DLY_W-1:0]       dly_len,
    input  logic                   bypass,
    output logic [2*NUM_PAIRS-1:0] drv_out
);
    localparam int NSIG = 2 * NUM_PAIRS;

    logic [NSIG-1:0] req_q;
    logic            tick_sel;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= drv_req;
    end

    dti_tick_sel u_tick (
        .src_sel (src_sel),
        .tick_a  (tick_a),
        .tick_b  (tick_b),
        .tick    (tick_sel)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pair_drv_t req_p;
        pair_drv_t prev_p;
        pair_drv_t rise_p;
        pair_drv_t out_p;
        logic      busy_p;
        logic      done_p;

        assign req_p  = drv_req[2*p +: 2];
        assign prev_p = req_q[2*p +: 2];
        assign rise_p = rising_bits(req_p, prev_p);

        dti_pair_timer #(.DLY_W(DLY_W)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .start  (|rise_p),
            .cancel (bypass),
            .tick   (tick_sel),
            .len    (dly_len),
            .busy   (busy_p),
            .done   (done_p)
        );

        dti_pair_gate u_gate (
            .clk    (clk),
            .rst    (rst),
            .req    (req_p),
            .rise   (rise_p),
            .done   (done_p),
            .bypass (bypass),
            .out    (out_p)
        );

        assign drv_out[2*p +: 2] = out_p;

        // R11: legal requests never give an overlapping pair
        a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
            (!bypass && !(req_p.pos && req_p.neg)) |=> !(drv_out[2*p] && drv_out[2*p+1]));

        for (genvar b = 0; b < 2; b++) begin : g_bit
            // R3: a delayed rise is released only on a selected tick
            a_r3_release_on_tick: assert property (@(posedge clk) disable iff (rst)
                ($rose(drv_out[2*p+b]) && !$past(bypass)) |-> $past(tick_sel));
        end
    end

    // R6: bypass makes outputs follow requests
    a_r6_bypass_follow: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (drv_out == $past(drv_req)));

endmodule

// File: tb/deadtime_inserter_tb_top.sv
module deadtime_inserter_tb_top;

    localparam int NP = 3;
    localparam int NS = 2 * NP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] drv_req = '0;
    logic          tick_a = 1'b0;
    logic          tick_b = 1'b0;
    logic          src_sel = 1'b0;
    logic [7:0]    dly_len = 8'd1;
    logic          bypass = 1'b0;
    logic [NS-1:0] drv_out;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    deadtime_inserter dut_i (
        .clk     (clk),
        .rst     (rst),
        .drv_req (drv_req),
        .tick_a  (tick_a),
        .tick_b  (tick_b),
        .src_sel (src_sel),
        .dly_len (dly_len),
        .bypass  (bypass),
        .drv_out (drv_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    // Reference model: ticks still needed per pair, pending holds per signal
    logic [NS-1:0] exp_out = '0;
    logic [NS-1:0] m_prev  = '0;
    logic [NS-1:0] m_pend  = '0;
    int            m_rem [NP];

    function automatic int eff_len(logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_out = '0;
            m_prev  = '0;
            m_pend  = '0;
            for (int p = 0; p < NP; p++) m_rem[p] = 0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                logic [1:0] r;
                logic [1:0] rs;
                logic       tk;
                logic       rel;
                r   = drv_req[2*p +: 2];
                rs  = r & ~m_prev[2*p +: 2];
                tk  = src_sel ? tick_b : tick_a;
                rel = 1'b0;
                if (bypass) begin
                    m_rem[p] = 0;
                    m_pend[2*p +: 2] = 2'b00;
                end else begin
                    if (rs != 2'b00) begin
                        m_rem[p] = eff_len(dly_len);
                    end else if (m_rem[p] > 0 && tk) begin
                        m_rem[p]--;
                        if (m_rem[p] == 0) rel = 1'b1;
                    end
                    m_pend[2*p +: 2] = ((rel ? 2'b00 : m_pend[2*p +: 2]) | rs) & r;
                end
                exp_out[2*p +: 2] = r & ~m_pend[2*p +: 2];
                m_prev[2*p +: 2]  = r;
            end
        end
    end

    // Every-cycle comparison against the model, plus the overlap rule
    always @(posedge clk) begin
        #1;
        if (!rst && !done_flag) begin
            chk(drv_out == exp_out, "R2/R3/R4/R6 model", int'(drv_out), int'(exp_out));
            if (!bypass) begin
                for (int p = 0; p < NP; p++)
                    chk(!(drv_out[2*p] && drv_out[2*p+1]), "R11 overlap",
                        int'(drv_out[2*p +: 2]), 0);
            end
        end
    end

    task automatic idle(input int n);
        drv_req = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise(input int bit_idx, input int limit, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!drv_out[bit_idx] && k < limit);
    endtask

    initial begin
        int k;
        int k2;
        int r0;
        int r1;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(drv_out == '0, "R1 during reset", int'(drv_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(drv_out == '0, "R1 after reset", int'(drv_out), 0);

        // R3: delay lengths with a tick every cycle
        tick_a = 1'b1; src_sel = 1'b0;
        dly_len = 8'd1;   drv_req = 6'b000001; wait_rise(0, 400, k);
        chk(k == 2, "R3 n=1", k, 2);
        idle(3);
        dly_len = 8'd5;   drv_req = 6'b000001; wait_rise(0, 400, k);
        chk(k == 6, "R3 n=5", k, 6);
        // R4: fall passes after one edge
        drv_req = 6'b000000; @(negedge clk);
        chk(drv_out[0] == 1'b0, "R4 fall", int'(drv_out[0]), 0);
        idle(3);
        dly_len = 8'd255; drv_req = 6'b000010; wait_rise(1, 400, k);
        chk(k == 256, "R3 n=255", k, 256);
        idle(3);

        // R9: zero acts as one
        dly_len = 8'd0; drv_req = 6'b000100; wait_rise(2, 50, k);
        chk(k == 2, "R9 zero length", k, 2);
        idle(3);

        // R7: unselected tick ignored
        src_sel = 1'b1; tick_a = 1'b1; tick_b = 1'b0; dly_len = 8'd3;
        drv_req = 6'b000100;
        repeat (20) @(negedge clk);
        chk(drv_out[2] == 1'b0, "R7 tick_a ignored", int'(drv_out[2]), 0);
        tick_b = 1'b1; wait_rise(2, 50, k);
        chk(k == 3, "R7 tick_b counts", k, 3);
        src_sel = 1'b0; idle(3);

        // R5: restart on a new rise in the same pair
        dly_len = 8'd10; drv_req = 6'b000001;
        repeat (5) @(negedge clk);
        drv_req = 6'b000010; wait_rise(1, 50, k);
        chk(k == 11, "R5 restart", k, 11);
        idle(3);

        // R8: length captured at trigger
        dly_len = 8'd4; drv_req = 6'b010000;
        @(negedge clk);
        dly_len = 8'd200; wait_rise(4, 300, k2);
        chk(k2 + 1 == 5, "R8 captured length", k2 + 1, 5);
        idle(3);

        // R10: pairs independent
        dly_len = 8'd6; drv_req = 6'b000001;
        repeat (3) @(negedge clk);
        dly_len = 8'd2; drv_req = 6'b000101;
        r0 = 0; r1 = 0;
        for (int c = 4; c <= 14; c++) begin
            @(negedge clk);
            if (drv_out[0] && r0 == 0) r0 = c;
            if (drv_out[2] && r1 == 0) r1 = c;
        end
        chk(r0 == 7, "R10 pair0 release", r0, 7);
        chk(r1 == 6, "R10 pair1 release", r1, 6);
        idle(3);

        // R6: bypass follows request with no dead time
        bypass = 1'b1; dly_len = 8'd50;
        drv_req = 6'b010000; @(negedge clk);
        chk(drv_out == 6'b010000, "R6 bypass rise", int'(drv_out), 16);
        drv_req = 6'b100000; @(negedge clk);
        chk(drv_out == 6'b100000, "R6 bypass swap", int'(drv_out), 32);
        bypass = 1'b0; idle(3);

        // Random traffic with legal pair patterns
        for (int i = 0; i < 4000; i++) begin
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 8 == 0) begin
                    case ($urandom % 3)
                        0:       drv_req[2*p +: 2] = 2'b00;
                        1:       drv_req[2*p +: 2] = 2'b01;
                        default: drv_req[2*p +: 2] = 2'b10;
                    endcase
                end
            end
            tick_a = 1'($urandom % 2);
            tick_b = ($urandom % 4) == 0;
            if ($urandom % 16 == 0) dly_len = 8'($urandom % 16);
            if ($urandom % 64 == 0) src_sel = ~src_sel;
            if ($urandom % 40 == 0) bypass = ~bypass;
            @(negedge clk);
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done_flag = 1'b1;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule